// File: doc/BRIEF.md
# Split-Read Result Register Interlock

This block holds a 10-bit conversion result behind an 8-bit bus as two readable bytes: a low byte with result bits 7:0 and a high byte with result bits 9:8, zero-extended. The conversion engine hands over each finished result with a one-cycle write strobe. The CPU reads the two bytes one at a time, and the block makes sure that both bytes belong to the same result.

Reading the low byte locks the pair. While the lock is set, any result that arrives is thrown away and both bytes keep their values. Reading the high byte releases the lock. The completion interrupt flag is raised by every result strobe, including one whose data was thrown away. Software clears the flag by writing one. A debug output pulses for one cycle after each discarded result.

Top module: `split_result_lock`

## Requirements
- R1: After reset, both bytes read as 0x00, the lock is clear, and `irq_o` and `drop_o` are low.
- R2: A result strobe taken while unlocked, with no low-byte read in the same cycle, is visible from the next cycle. A low-byte read returns result bits 7:0. A high-byte read returns result bits 9:8 in data bits 1:0, with data bits 7:2 at zero.
- R3: A low-byte read sets the lock. Result strobes that arrive while the lock is set leave both bytes unchanged.
- R4: A high-byte read clears the lock, so a result strobe in a later cycle is stored.
- R5: A result strobe in the same cycle as the high-byte read that clears the lock is dropped.
- R6: A result strobe in the same cycle as a low-byte read is dropped, and that read returns the old low byte.
- R7: `irq_o` is high in the cycle after every result strobe, whether the data was stored or dropped.
- R8: When `irq_clr_i` is high and no result strobe is present, `irq_o` is low in the next cycle. A strobe in the same cycle as the clear wins, and `irq_o` stays high.
- R9: A high-byte read while unlocked has no effect other than returning data. A later result strobe is still stored.
- R10: `drop_o` is high for exactly the one cycle after a dropped result strobe, and low after a strobe that was stored.
- R11: `rd_data_o` is combinational from the current register state and reads 0x00 in any cycle with neither read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_wr_i | input | 1 | Result write strobe from the conversion engine |
| res_data_i | input | RES_W | Result value |
| rd_lo_i | input | 1 | CPU read strobe for the low byte |
| rd_hi_i | input | 1 | CPU read strobe for the high byte |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| rd_data_o | output | BYTE_W | Read data |
| irq_o | output | 1 | Conversion-complete interrupt flag |
| drop_o | output | 1 | One-cycle pulse after a discarded result |

## Verification
The bench sends results into the locked window from three sides: while the lock is already held, in the same cycle as the releasing high-byte read, and in the same cycle as the locking low-byte read. A design that opens the lock one cycle early would store the result that arrives with the high-byte read. A design that locks one cycle late would return a low byte from one result and a high byte from another. The bench also checks that the interrupt still rises for discarded results, and that a set wins over a simultaneous clear. A flag that follows only stored results, or lets the clear win, fails these checks. Finally, the bench reads the high byte with no lock held and confirms that later writes still land. A design that toggles the lock on any read would fail this check.

// File: rtl/split_rd_pkg.sv
package split_rd_pkg;
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_st_e;
endpackage

// File: rtl/srl_lock_ctrl.sv
module srl_lock_ctrl
  import split_rd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic held_o,
  output logic block_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rd_lo_i)      st_d = LK_HELD;  // low read wins if both strobes coincide
    else if (rd_hi_i) st_d = LK_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_OPEN;
    else         st_q <= st_d;
  end

  assign held_o  = (st_q == LK_HELD);
  // a low read in the same cycle already shields the pair
  assign block_o = held_o | rd_lo_i;
endmodule

// File: rtl/srl_result_store.sv
module srl_result_store #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  localparam int HI_W  = RES_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RES_W-1:0]  data_i,
  input  logic              block_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              drop_o
);
  logic take;
  assign take = wr_i & ~block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o   <= '0;
      hi_o   <= '0;
      drop_o <= 1'b0;
    end else begin
      drop_o <= wr_i & block_i;
      if (take) begin
        lo_o <= data_i[BYTE_W-1:0];
        hi_o <= data_i[RES_W-1:BYTE_W];
      end
    end
  end
endmodule

// File: rtl/srl_irq_flag.sv
module srl_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/srl_read_mux.sv
module srl_read_mux #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  localparam int HI_W  = RES_W - BYTE_W
) (
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] hi_ext;

  generate
    if (HI_W < BYTE_W) begin : g_pad
      assign hi_ext = {{(BYTE_W-HI_W){1'b0}}, hi_i};
    end else begin : g_full
      assign hi_ext = hi_i;
    end
  endgenerate

  always_comb begin
    if (rd_lo_i)      data_o = lo_i;
    else if (rd_hi_i) data_o = hi_ext;
    else              data_o = '0;
  end
endmodule

// File: rtl/split_result_lock.sv
module split_result_lock #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  localparam int HI_W  = RES_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_wr_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              irq_clr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              drop_o
);
  logic              lock_held;
  logic              lock_block;
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  srl_lock_ctrl u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .held_o  (lock_held),
    .block_o (lock_block)
  );

  srl_result_store #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (res_wr_i),
    .data_i  (res_data_i),
    .block_i (lock_block),
    .lo_o    (lo_q),
    .hi_o    (hi_q),
    .drop_o  (drop_o)
  );

  srl_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (res_wr_i),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  srl_read_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/split_result_lock_chk.sv
module split_result_lock_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8,
  localparam int HI_W  = RES_W - BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_wr_i,
  input logic [RES_W-1:0]  res_data_i,
  input logic              rd_lo_i,
  input logic              rd_hi_i,
  input logic              irq_clr_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic              drop_o,
  input logic              lock_held,
  input logic [BYTE_W-1:0] lo_q,
  input logic [HI_W-1:0]   hi_q
);
  assert_store_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_wr_i && !lock_held && !rd_lo_i) |=> lo_q == $past(res_data_i[BYTE_W-1:0]));

  assert_hi_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |-> rd_data_o[BYTE_W-1:HI_W] == '0);

  assert_lock_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> lock_held);

  assert_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_held && !rd_hi_i) |=> $stable(lo_q) && $stable(hi_q));

  assert_unlock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |=> !lock_held);

  assert_rel_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_held && rd_hi_i && res_wr_i) |=> $stable(lo_q) && drop_o);

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_wr_i |=> irq_o);

  assert_irq_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !res_wr_i) |=> !irq_o);

  assert_drop_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_wr_i |=> !drop_o);

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !rd_hi_i) |-> rd_data_o == '0);
endmodule

bind split_result_lock split_result_lock_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .res_wr_i   (res_wr_i),
  .res_data_i (res_data_i),
  .rd_lo_i    (rd_lo_i),
  .rd_hi_i    (rd_hi_i),
  .irq_clr_i  (irq_clr_i),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o),
  .drop_o     (drop_o),
  .lock_held  (lock_held),
  .lo_q       (lo_q),
  .hi_q       (hi_q)
);

// File: tb/split_result_lock_test.sv
module split_result_lock_test;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              res_wr = 1'b0;
  logic [RES_W-1:0]  res_data = '0;
  logic              rd_lo = 1'b0;
  logic              rd_hi = 1'b0;
  logic              irq_clr = 1'b0;
  logic [BYTE_W-1:0] rd_data;
  logic              irq;
  logic              drop;

  int n_cmp = 0;
  int n_bad = 0;
  logic [BYTE_W-1:0] exp_q[$];
  string             tag_q[$];

  always #10 clk = ~clk;

  split_result_lock #(.RES_W(RES_W), .BYTE_W(BYTE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .res_wr_i(res_wr), .res_data_i(res_data),
    .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .irq_clr_i(irq_clr),
    .rd_data_o(rd_data), .irq_o(irq), .drop_o(drop)
  );

  task automatic check(input string req, input logic [BYTE_W-1:0] act, input logic [BYTE_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one active cycle, then inputs return to idle; returns 5 ns into the idle cycle
  task automatic step(input logic wr, input logic [RES_W-1:0] d, input logic lo,
                      input logic hi, input logic clr);
    @(negedge clk);
    res_wr = wr; res_data = d; rd_lo = lo; rd_hi = hi; irq_clr = clr;
    @(negedge clk);
    res_wr = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0; irq_clr = 1'b0;
    #5;
  endtask

  task automatic rd(input logic lo, input logic [BYTE_W-1:0] exp, input string req,
                    input logic wr = 1'b0, input logic [RES_W-1:0] d = '0);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    step(wr, d, lo, ~lo, 1'b0);
  endtask

  // monitor: compares read data mid low phase of each read cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_lo || rd_hi) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: actual %h expected none", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 drop", {7'd0, drop}, 8'h00);
    check("R11 idle", rd_data, 8'h00);
    rd(1'b1, 8'h00, "R1 lo");
    rd(1'b0, 8'h00, "R1 hi");

    step(1'b1, 10'h2A5, 1'b0, 1'b0, 1'b0);
    check("R7 irq", {7'd0, irq}, 8'h01);
    check("R10 no drop", {7'd0, drop}, 8'h00);
    rd(1'b1, 8'hA5, "R2 lo");
    rd(1'b0, 8'h02, "R2 hi");
    check("R11 idle", rd_data, 8'h00);

    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R8 clear", {7'd0, irq}, 8'h00);

    // R3: writes while locked are lost
    step(1'b1, 10'h15A, 1'b0, 1'b0, 1'b0);
    rd(1'b1, 8'h5A, "R3 lo");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 10'h3FF, 1'b0, 1'b0, 1'b0);
    check("R10 drop", {7'd0, drop}, 8'h01);
    check("R7 irq dropped", {7'd0, irq}, 8'h01);
    step(1'b1, 10'h0C3, 1'b0, 1'b0, 1'b0);
    rd(1'b0, 8'h01, "R3 hi");
    check("R10 pulse end", {7'd0, drop}, 8'h00);

    // R4: unlocked again
    step(1'b1, 10'h081, 1'b0, 1'b0, 1'b0);
    check("R10 stored", {7'd0, drop}, 8'h00);
    rd(1'b1, 8'h81, "R4 lo");

    // R5: write with the releasing high read
    rd(1'b0, 8'h00, "R5 hi", 1'b1, 10'h2F0);
    check("R10 drop R5", {7'd0, drop}, 8'h01);
    rd(1'b1, 8'h81, "R5 lo");
    rd(1'b0, 8'h00, "R5 hi2");

    // R6: write with the locking low read
    rd(1'b1, 8'h81, "R6 lo", 1'b1, 10'h1E7);
    check("R10 drop R6", {7'd0, drop}, 8'h01);
    rd(1'b0, 8'h00, "R6 hi");
    rd(1'b1, 8'h81, "R6 lo2");
    rd(1'b0, 8'h00, "R6 hi2");

    // R9: high read without lock
    rd(1'b0, 8'h00, "R9 hi");
    step(1'b1, 10'h2C4, 1'b0, 1'b0, 1'b0);
    check("R9 no drop", {7'd0, drop}, 8'h00);
    rd(1'b1, 8'hC4, "R9 lo");
    rd(1'b0, 8'h02, "R9 hi2");

    // R8: set beats clear
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R8 clear2", {7'd0, irq}, 8'h00);
    step(1'b1, 10'h333, 1'b0, 1'b0, 1'b1);
    check("R8 priority", {7'd0, irq}, 8'h01);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R8 clear3", {7'd0, irq}, 8'h00);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R8 clear idle", {7'd0, irq}, 8'h00);
    rd(1'b1, 8'h33, "R2 lo2");
    rd(1'b0, 8'h03, "R2 hi3");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule